// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Master

This block is a master-only serial port with four pins: two active-high device enables, a serial clock that the block generates itself, and one data line shared by both directions. Software places a byte in the data register, then writes the control register. That write selects which enables are driven, chooses the direction and the clock divider, and starts the transfer with its start bit. The port then moves eight bits, most significant first. It has no slave mode, no DMA and no interrupts.

Software polls the status register. A busy bit stays set for the whole transfer. When the last bit ends, a transmit-done or receive-done flag is set, and reading the status register clears it. The data line is split into an output value, an output enable and an input. The output enable is high only while a transmit is running. The enables stay asserted after a transfer ends, so back-to-back transfers share a single select window. They drop only when software writes the control register again.

Register map (byte wide, `bus_addr`): 0 = data, 1 = control, 2 = status, 3 reads as zero. Control bits: [1:0] enable mask (bit0 drives `dev_en[0]`, bit1 drives `dev_en[1]`), [2] direction (1 = transmit, 0 = receive), [3] start, [5:4] divider code `d`, [7:6] spare bits that are stored and read back. Status bits: [0] busy, [1] transmit done, [2] receive done.

Top module: `ssm_master`

## Requirements
- R1: After reset, `dev_en`, `sclk`, `sdata_out` and `sdata_oe` are all 0, and a status read returns 0.
- R2: A control write with start=1 while idle sets busy and drives `dev_en` from control bits [1:0]. `dev_en` keeps that value after the transfer completes, until the next accepted control write; a control write with start=0 changes the enables without starting a transfer.
- R3: With divider code d (control bits [5:4]), each half of the serial clock period lasts H = 2^d system clocks, giving division by 2, 4, 8 or 16. Busy stays set for exactly 18*H system clocks after the accepting edge.
- R4: A transmit sends the byte last written to address 0, most significant bit first. `sdata_out` changes only while `sclk` is low and holds steady while `sclk` is high.
- R5: A receive samples `sdata_in` at the system clock edge where `sclk` rises, so the input needs setup before that rise. Bits are taken most significant first, and the byte is read back at address 0 once busy has cleared.
- R6: `sdata_oe` is high only during a transmit. It stays low for the whole of a receive and whenever the port is idle.
- R7: At the edge where busy clears, status bit 1 (after a transmit) or bit 2 (after a receive) is set. A status read clears both flags. If completion and a read fall on the same edge, the flag is set.
- R8: A control write of any value while busy is ignored. The enables, the clock divider, the transfer length and the byte sent do not change.
- R9: `sclk` idles low. The first rising edge of `sclk` comes 3*H system clocks after the accepting edge, which leaves one full serial clock period of enable lead before the first bit. Exactly eight rising edges occur per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears done flags at status address) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| dev_en | output | 2 | Device enables, active high |
| sclk | output | 1 | Serial clock, idle low |
| sdata_out | output | 1 | Data line output value |
| sdata_oe | output | 1 | Data line output enable |
| sdata_in | input | 1 | Data line input value |

## Verification
The assertions assume that software follows the polling rule. A start is accepted only while busy is low, so the checker resets its rising-edge counter at every accepted start and tests the count only when busy falls. The checks on steady data and steady enables rely on bus writes being ignored while busy. The stimulus exercises that by writing the control register in the middle of a transfer. The stimulus otherwise starts transfers only after a status read has shown busy clear. The bench's serial device model changes `sdata_in` only on falling `sclk` edges, which keeps the receive input settled before each sampling edge.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef enum logic [1:0] {
    SSM_A_DATA = 2'd0,
    SSM_A_CTRL = 2'd1,
    SSM_A_STAT = 2'd2,
    SSM_A_NONE = 2'd3
  } ssm_addr_e;

  // control byte layout, low six bits carry function
  localparam int unsigned CTL_EN_LO  = 0;
  localparam int unsigned CTL_TX_BIT = 2;
  localparam int unsigned CTL_GO_BIT = 3;
  localparam int unsigned CTL_DV_LO  = 4;
  localparam int unsigned CTL_USED   = 6;

  // half serial period in system clocks for a divider code
  function automatic int unsigned ssm_half_len(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // half-period index at which the serial clock is high
  function automatic logic ssm_high_half(input int unsigned ph);
    return (ph[0] == 1'b1) && (ph >= 3);
  endfunction

  // whole transfer length in half periods: lead period plus two per bit
  function automatic int unsigned ssm_halves(input int unsigned bits);
    return 2 + 2 * bits;
  endfunction

endpackage

// File: rtl/ssm_divider.sv
module ssm_divider
  import ssm_pkg::*;
#(
  parameter int unsigned DIVW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] code,
  output logic            tick
);
  localparam int unsigned MAXH = 1 << ((1 << DIVW) - 1);
  localparam int unsigned CW   = (MAXH > 1) ? $clog2(MAXH) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = CW'(ssm_half_len(int'(code)) - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ssm_sequencer.sv
module ssm_sequencer
  import ssm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic sclk,
  output logic rise_ev,
  output logic fall_ev,
  output logic last_ev
);
  localparam int unsigned NHALF = ssm_halves(DW);
  localparam int unsigned PHW   = $clog2(NHALF + 1);
  localparam logic [PHW-1:0] LAST = PHW'(NHALF - 1);

  logic [PHW-1:0] ph;
  logic [PHW-1:0] ph_nx;
  logic           at_last;

  assign ph_nx   = ph + 1'b1;
  assign at_last = (ph == LAST);
  assign last_ev = busy && tick && at_last;
  assign rise_ev = busy && tick && !at_last && ssm_high_half(int'(ph_nx));
  assign fall_ev = busy && tick && !at_last && ssm_high_half(int'(ph));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
      sclk <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      ph   <= '0;
      sclk <= 1'b0;
    end else if (busy && tick) begin
      if (at_last) begin
        busy <= 1'b0;
        ph   <= '0;
        sclk <= 1'b0;
      end else begin
        ph   <= ph_nx;
        sclk <= ssm_high_half(int'(ph_nx));
      end
    end
  end

endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift_out,
  input  logic          shift_in,
  input  logic          sin,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (shift_in) begin
      q <= {q[DW-2:0], sin};
    end else if (shift_out) begin
      q <= {q[DW-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/ssm_master.sv
module ssm_master
  import ssm_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned DIVW = 2,
  parameter int unsigned NEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NEN-1:0] dev_en,
  output logic          sclk,
  output logic          sdata_out,
  output logic          sdata_oe,
  input  logic          sdata_in
);
  localparam int unsigned SPW = DW - CTL_USED;

  // named internal events
  logic busy_w, go_w, ctl_wr_w, stat_rd_w, data_wr_w;
  logic tick_w, rise_w, fall_w, last_w;

  logic [DW-1:0]   hold_q;
  logic [DW-1:0]   shreg;
  logic [NEN-1:0]  en_q;
  logic            tx_q;
  logic [DIVW-1:0] div_q;
  logic [SPW-1:0]  spare_q;
  logic            txdone_q, rxdone_q;

  assign data_wr_w = bus_wr && (bus_addr == SSM_A_DATA);
  assign ctl_wr_w  = bus_wr && (bus_addr == SSM_A_CTRL) && !busy_w;
  assign go_w      = ctl_wr_w && bus_wdata[CTL_GO_BIT];
  assign stat_rd_w = bus_rd && (bus_addr == SSM_A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (data_wr_w) begin
      hold_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      tx_q    <= 1'b0;
      div_q   <= '0;
      spare_q <= '0;
    end else if (ctl_wr_w) begin
      en_q    <= bus_wdata[CTL_EN_LO +: NEN];
      tx_q    <= bus_wdata[CTL_TX_BIT];
      div_q   <= bus_wdata[CTL_DV_LO +: DIVW];
      spare_q <= bus_wdata[DW-1:CTL_USED];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txdone_q <= 1'b0;
      rxdone_q <= 1'b0;
    end else if (last_w) begin
      txdone_q <= tx_q;
      rxdone_q <= !tx_q;
    end else if (stat_rd_w) begin
      txdone_q <= 1'b0;
      rxdone_q <= 1'b0;
    end
  end

  ssm_divider #(.DIVW(DIVW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_w),
    .code (div_q),
    .tick (tick_w)
  );

  ssm_sequencer #(.DW(DW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (go_w),
    .tick   (tick_w),
    .busy   (busy_w),
    .sclk   (sclk),
    .rise_ev(rise_w),
    .fall_ev(fall_w),
    .last_ev(last_w)
  );

  ssm_shifter #(.DW(DW)) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go_w),
    .load_val (hold_q),
    .shift_out(fall_w && tx_q),
    .shift_in (rise_w && !tx_q),
    .sin      (sdata_in),
    .q        (shreg)
  );

  assign dev_en    = en_q;
  assign sdata_oe  = busy_w && tx_q;
  assign sdata_out = sdata_oe && shreg[DW-1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      SSM_A_DATA: bus_rdata = shreg;
      SSM_A_CTRL: begin
        bus_rdata[CTL_EN_LO +: NEN]   = en_q;
        bus_rdata[CTL_TX_BIT]         = tx_q;
        bus_rdata[CTL_DV_LO +: DIVW]  = div_q;
        bus_rdata[DW-1:CTL_USED]      = spare_q;
      end
      SSM_A_STAT: bus_rdata[2:0] = {rxdone_q, txdone_q, busy_w};
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ssm_master_chk.sv
module ssm_master_chk #(
  parameter int unsigned DW  = 8,
  parameter int unsigned NEN = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy_w,
  input logic           go_w,
  input logic [NEN-1:0] dev_en,
  input logic           sclk,
  input logic           sdata_out,
  input logic           sdata_oe,
  input logic           txdone,
  input logic           rxdone
);
  localparam int unsigned RCW = $clog2(DW + 2);

  logic           sclk_d;
  logic [RCW-1:0] nrise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      nrise  <= '0;
    end else begin
      sclk_d <= sclk;
      if (go_w) nrise <= '0;
      else if (sclk && !sclk_d) nrise <= nrise + 1'b1;
    end
  end

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && $past(busy_w)) |-> $stable(dev_en));

  // R9
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !sclk);

  // R4
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata_out));

  // R6
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !sdata_oe);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(txdone) || $rose(rxdone)) |-> $fell(busy_w));

  // R9
  eight_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_w) |-> (nrise == RCW'(DW)));

endmodule

bind ssm_master ssm_master_chk #(.DW(DW), .NEN(NEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_w   (busy_w),
  .go_w     (go_w),
  .dev_en   (dev_en),
  .sclk     (sclk),
  .sdata_out(sdata_out),
  .sdata_oe (sdata_oe),
  .txdone   (txdone_q),
  .rxdone   (rxdone_q)
);

// File: tb/ssm_master_bench.sv
module ssm_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [1:0] dev_en;
  logic       sclk, sdata_out, sdata_oe, sdata_in;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  ssm_master u_ssm_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_en(dev_en), .sclk(sclk), .sdata_out(sdata_out),
    .sdata_oe(sdata_oe), .sdata_in(sdata_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // serial device model: presents slv_byte MSB first, advances on falling sclk
  logic [7:0] slv_byte = 8'h00;
  int         sidx = 0;
  assign sdata_in = slv_byte[7 - sidx];
  always @(negedge sclk) if (sidx < 7) sidx++;

  // scoreboard for transmitted bytes
  logic [7:0] exp_q[$];
  logic [7:0] cap = 8'h00;
  int         ncap = 0;
  always @(posedge sclk) begin
    if (sdata_oe) begin
      cap = {cap[6:0], sdata_out};
      ncap++;
      if (ncap == 8) begin
        ncap = 0;
        if (exp_q.size() == 0) chk("R4 unexpected byte", {24'd0, cap}, 32'hFFFF);
        else chk("R4 byte sent MSB first", {24'd0, cap}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // start with ctrl, poll status each cycle; optional control write at cycle poke
  task automatic xfer(input logic [7:0] ctl, input int poke, input logic [7:0] pval,
                      input logic [1:0] exp_en, output int ncyc, output int first,
                      output bit oe_seen, output bit en_bad);
    int n;
    bit b;
    n = 0; first = -1; oe_seen = 0; en_bad = 0;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = ctl;
    @(negedge clk);
    forever begin
      if (n == poke) begin
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = 2'd1; bus_wdata = pval; b = 1'b1;
      end else begin
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 2'd2;
        #1 b = bus_rdata[0];
      end
      if (!b) break;
      if (sclk && first < 0) first = n;
      if (sdata_oe) oe_seen = 1;
      if (dev_en !== exp_en) en_bad = 1;
      n++;
      @(negedge clk);
      if (n > 5000) break;
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    ncyc = n;
  endtask

  task automatic do_tx(input logic [7:0] b, input logic [1:0] en, input int d,
                       input int poke, input logic [7:0] pval);
    int nc, fr;
    bit oe, eb;
    int h;
    h = 1 << d;
    wr(2'd0, b);
    exp_q.push_back(b);
    xfer({2'b00, 2'(d), 1'b1, 1'b1, en}, poke, pval, en, nc, fr, oe, eb);
    chk("R3 busy length tx", nc, 18 * h);
    chk("R9 first sclk rise", fr, 3 * h);
    chk("R6 oe high during tx", {31'd0, oe}, 1);
    chk("R2 enables held during tx", {31'd0, eb}, 0);
  endtask

  task automatic do_rx(input logic [7:0] b, input logic [1:0] en, input int d);
    int nc, fr;
    bit oe, eb;
    logic [7:0] got;
    int h;
    h = 1 << d;
    slv_byte = b; sidx = 0;
    xfer({2'b00, 2'(d), 1'b1, 1'b0, en}, -1, 8'h00, en, nc, fr, oe, eb);
    chk("R3 busy length rx", nc, 18 * h);
    chk("R6 oe low during rx", {31'd0, oe}, 0);
    rd(2'd0, got);
    chk("R5 received byte", {24'd0, got}, {24'd0, b});
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dev_en", {30'd0, dev_en}, 0);
    chk("R1 sclk", {31'd0, sclk}, 0);
    chk("R1 oe", {31'd0, sdata_oe}, 0);
    rst_n = 1'b1;
    rd(2'd2, s);
    chk("R1 status", {24'd0, s}, 0);

    do_tx(8'hA5, 2'b01, 0, -1, 8'h00);
    chk("R2 enable kept after done", {30'd0, dev_en}, 2'b01);
    rd(2'd2, s);
    chk("R7 tx done flag", {24'd0, s}, 32'h2);
    rd(2'd2, s);
    chk("R7 cleared by read", {24'd0, s}, 0);

    do_tx(8'h3C, 2'b10, 2, -1, 8'h00);
    do_rx(8'h96, 2'b01, 1);
    rd(2'd2, s);
    chk("R7 rx done flag", {24'd0, s}, 32'h4);

    // R8: control write mid-transfer must be ignored
    do_tx(8'hC3, 2'b01, 3, 20, 8'b00_00_1_1_10);
    chk("R8 enables unchanged", {30'd0, dev_en}, 2'b01);
    rd(2'd1, s);
    chk("R8 ctrl divider unchanged", {30'd0, s[5:4]}, 3);

    do_tx(8'hFF, 2'b11, 0, -1, 8'h00);
    do_tx(8'h00, 2'b11, 0, -1, 8'h00);
    do_rx(8'h01, 2'b10, 3);
    do_rx(8'h80, 2'b10, 0);

    wr(2'd1, 8'h00);
    @(negedge clk);
    chk("R2 enables cleared by write", {30'd0, dev_en}, 0);
    rd(2'd2, s);
    chk("R2 no start without start bit", {31'd0, s[0]}, 0);
    chk("R4 all bytes seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule